// File: doc/BRIEF.md
# Inbound Address Window Translator

This block remaps the address of every incoming memory request through a set of programmable windows. Each window has a base address, a power-of-two size and a local target address. When a request address falls inside an enabled window, the bits below the window size pass through unchanged. The bits above the size are replaced by the matching bits of the window's target. The block reports the matching window's index alongside the result.

Two operating modes are available, selected per request by `rc_mode`. In endpoint mode (`rc_mode`=0) all `NUM_WIN` windows (six by default) take part, and an address that hits none of them is rejected. In root-complex mode (`rc_mode`=1) only windows 0 and 1 take part, and an address that hits neither leaves the block unchanged.

Software fills the window table through a one-cycle write port. Every write is checked for alignment against the window size. Misaligned low bits are never honoured: the block drops them, so a mapping always lands on the aligned-down boundary. Such a write also leaves a sticky per-window flag. Requests move through one register stage with a valid/ready handshake.

Top module: `inbound_win_xlate`

## Requirements
- R1: In endpoint mode, an address that falls inside enabled window i produces `out_hit`=1, `out_miss`=0 and `out_win`=i. The output address takes the target bits at and above the window size and the address bits below it. Config selector `cfg_sel` writes the base when 0, the target when 1 and the control word when 2.
- R2: The control word holds the enable in bit 8 and log2 of the size in bits [5:0]. A size below 12 is treated as 12, so the smallest window is 4 KB. A window whose enable is 0 never matches.
- R3: When several enabled windows match the same address, the lowest-numbered window is reported and used for translation.
- R4: In endpoint mode, an address that matches no window gives `out_miss`=1, `out_hit`=0 and `out_addr`=0.
- R5: In root-complex mode, only windows 0 and 1 are considered. An address that matches neither comes out unchanged with `out_hit`=0 and `out_miss`=0.
- R6: Target bits below the window size are ignored. For example, a 16 KB window with target 0x7000_5000 maps offset 0 to 0x7000_4000 and offset 0x3FFC to 0x7000_7FFC.
- R7: Base bits below the window size are ignored for matching, so a misaligned base matches the aligned-down window.
- R8: Bit i of `misalign_flags` is set when any of these writes leaves window i with nonzero bits below its size:
  - a base or target write, checked against the current size;
  - a control write, checked against the new size applied to the stored base and target.

  The bit stays set until reset.
- R9: `in_ready` is `!out_valid || out_ready`. An accepted request appears on the outputs with `out_valid`=1 one clock later. While `out_valid`=1 and `out_ready`=0, the outputs hold steady.
- R10: After reset, `out_valid`=0, `in_ready`=1, every window is disabled, and all `misalign_flags` bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rc_mode | input | 1 | 1 selects root-complex mode, 0 endpoint mode |
| cfg_we | input | 1 | Config write strobe |
| cfg_win | input | WIN_IDX_W | Window index of the write |
| cfg_sel | input | 2 | 0 base, 1 target, 2 control |
| cfg_wdata | input | ADDR_W | Write data |
| misalign_flags | output | NUM_WIN | Sticky misalignment flag per window |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted this cycle when valid |
| in_addr | input | ADDR_W | Request address |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_addr | output | ADDR_W | Translated, passed or zero address |
| out_hit | output | 1 | A window matched |
| out_miss | output | 1 | Endpoint-mode rejection |
| out_win | output | WIN_IDX_W | Index of the matching window |

## Verification
The bench aims at the window edges, offsets 0 and size-1. A comparator with an off-by-one mask would accept or refuse the wrong byte there. It also programs a target 4 KB off a 16 KB boundary. A design that kept the target's low bits would place the data at the intended buffer, not 4 KB below it. Overlapping windows show whether priority is inverted, and a window outside the root-complex pair checks that an unused window is still ignored. A stalled output checks that a pipeline dropping or overwriting the held result is caught. The sticky flags are probed after an aligned rewrite, to catch a flag that clears.

// File: rtl/inbound_win_pkg.sv
package inbound_win_pkg;

    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_TARGET = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    localparam int CTRL_EN_BIT = 8;
    localparam int MIN_SIZE_LOG2 = 12;

endpackage

// File: rtl/iwx_cfg_regs.sv
module iwx_cfg_regs #(
    parameter int NUM_WIN   = 6,
    parameter int ADDR_W    = 32,
    parameter int WIN_IDX_W = 3,
    parameter int SZ_W      = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [WIN_IDX_W-1:0]               cfg_win,
    input  logic [1:0]                         cfg_sel,
    input  logic [ADDR_W-1:0]                  cfg_wdata,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]     base,
    output logic [NUM_WIN-1:0][ADDR_W-1:0]     target,
    output logic [NUM_WIN-1:0][SZ_W-1:0]       size,
    output logic [NUM_WIN-1:0]                 en,
    output logic [NUM_WIN-1:0]                 misalign
);
    import inbound_win_pkg::*;

    localparam logic [SZ_W-1:0] MIN_SZ = SZ_W'(MIN_SIZE_LOG2);
    localparam logic [SZ_W-1:0] MAX_SZ = SZ_W'(ADDR_W - 1);

    typedef struct packed {
        logic [NUM_WIN-1:0][ADDR_W-1:0] base;
        logic [NUM_WIN-1:0][ADDR_W-1:0] target;
        logic [NUM_WIN-1:0][SZ_W-1:0]   size;
        logic [NUM_WIN-1:0]             en;
        logic [NUM_WIN-1:0]             mis;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    function automatic logic [ADDR_W-1:0] low_mask(input logic [SZ_W-1:0] s);
        return (ADDR_W'(1) << s) - ADDR_W'(1);
    endfunction

    function automatic logic [SZ_W-1:0] clamp_size(input logic [SZ_W-1:0] s);
        if (s < MIN_SZ)      return MIN_SZ;
        else if (s > MAX_SZ) return MAX_SZ;
        else                 return s;
    endfunction

    always_comb begin
        logic [SZ_W-1:0]   new_sz;
        logic [ADDR_W-1:0] cur_mask;
        st_d     = st_q;
        new_sz   = '0;
        cur_mask = '0;
        if (cfg_we && (int'(cfg_win) < NUM_WIN)) begin
            cur_mask = low_mask(st_q.size[cfg_win]);
            unique case (cfg_sel_e'(cfg_sel))
                SEL_BASE: begin
                    st_d.base[cfg_win] = cfg_wdata;
                    if ((cfg_wdata & cur_mask) != '0) st_d.mis[cfg_win] = 1'b1;
                end
                SEL_TARGET: begin
                    st_d.target[cfg_win] = cfg_wdata;
                    if ((cfg_wdata & cur_mask) != '0) st_d.mis[cfg_win] = 1'b1;
                end
                SEL_CTRL: begin
                    new_sz = clamp_size(cfg_wdata[SZ_W-1:0]);
                    st_d.size[cfg_win] = new_sz;
                    st_d.en[cfg_win]   = cfg_wdata[CTRL_EN_BIT];
                    if (((st_q.base[cfg_win] | st_q.target[cfg_win]) & low_mask(new_sz)) != '0)
                        st_d.mis[cfg_win] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.base   <= '0;
            st_q.target <= '0;
            st_q.size   <= {NUM_WIN{MIN_SZ}};
            st_q.en     <= '0;
            st_q.mis    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign base     = st_q.base;
    assign target   = st_q.target;
    assign size     = st_q.size;
    assign en       = st_q.en;
    assign misalign = st_q.mis;

endmodule

// File: rtl/iwx_matcher.sv
module iwx_matcher #(
    parameter int NUM_WIN   = 6,
    parameter int RC_WINS   = 2,
    parameter int ADDR_W    = 32,
    parameter int WIN_IDX_W = 3,
    parameter int SZ_W      = 6
) (
    input  logic                           rc_mode,
    input  logic [ADDR_W-1:0]              in_addr,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] base,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] target,
    input  logic [NUM_WIN-1:0][SZ_W-1:0]   size,
    input  logic [NUM_WIN-1:0]             en,
    output logic                           hit,
    output logic                           miss,
    output logic [WIN_IDX_W-1:0]           win,
    output logic [ADDR_W-1:0]              xaddr
);
    logic [NUM_WIN-1:0]             cand;
    logic [NUM_WIN-1:0][ADDR_W-1:0] remap;

    function automatic logic [ADDR_W-1:0] low_mask(input logic [SZ_W-1:0] s);
        return (ADDR_W'(1) << s) - ADDR_W'(1);
    endfunction

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [ADDR_W-1:0] m;
        logic              in_range;
        logic              allowed;
        assign m        = low_mask(size[g]);
        assign in_range = ((in_addr ^ base[g]) & ~m) == '0;
        assign allowed  = en[g] && (!rc_mode || (g < RC_WINS));
        assign cand[g]  = in_range && allowed;
        assign remap[g] = (target[g] & ~m) | (in_addr & m);
    end

    always_comb begin
        hit   = 1'b0;
        win   = '0;
        xaddr = rc_mode ? in_addr : '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit   = 1'b1;
                win   = WIN_IDX_W'(i);
                xaddr = remap[i];
            end
        end
        miss = !hit && !rc_mode;
    end

endmodule

// File: rtl/iwx_out_stage.sv
module iwx_out_stage #(
    parameter int ADDR_W    = 32,
    parameter int WIN_IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 nx_hit,
    input  logic                 nx_miss,
    input  logic [WIN_IDX_W-1:0] nx_win,
    input  logic [ADDR_W-1:0]    nx_addr,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 out_hit,
    output logic                 out_miss,
    output logic [WIN_IDX_W-1:0] out_win,
    output logic [ADDR_W-1:0]    out_addr
);
    typedef struct packed {
        logic                 vld;
        logic                 hit;
        logic                 miss;
        logic [WIN_IDX_W-1:0] win;
        logic [ADDR_W-1:0]    addr;
    } stage_t;

    stage_t st_d, st_q;

    assign in_ready = !st_q.vld || out_ready;

    always_comb begin
        st_d = st_q;
        if (in_valid && in_ready) begin
            st_d.vld  = 1'b1;
            st_d.hit  = nx_hit;
            st_d.miss = nx_miss;
            st_d.win  = nx_win;
            st_d.addr = nx_addr;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_hit   = st_q.hit;
    assign out_miss  = st_q.miss;
    assign out_win   = st_q.win;
    assign out_addr  = st_q.addr;

endmodule

// File: rtl/inbound_win_xlate.sv
module inbound_win_xlate #(
    parameter  int NUM_WIN   = 6,
    parameter  int RC_WINS   = 2,
    parameter  int ADDR_W    = 32,
    localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rc_mode,
    input  logic                 cfg_we,
    input  logic [WIN_IDX_W-1:0] cfg_win,
    input  logic [1:0]           cfg_sel,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    output logic [NUM_WIN-1:0]   misalign_flags,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [ADDR_W-1:0]    in_addr,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 out_hit,
    output logic                 out_miss,
    output logic [WIN_IDX_W-1:0] out_win
);
    localparam int SZ_W = $clog2(ADDR_W) + 1;

    logic [NUM_WIN-1:0][ADDR_W-1:0] w_base;
    logic [NUM_WIN-1:0][ADDR_W-1:0] w_target;
    logic [NUM_WIN-1:0][SZ_W-1:0]   w_size;
    logic [NUM_WIN-1:0]             w_en;
    logic                           m_hit, m_miss;
    logic [WIN_IDX_W-1:0]           m_win;
    logic [ADDR_W-1:0]              m_addr;

    iwx_cfg_regs #(
        .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .WIN_IDX_W(WIN_IDX_W), .SZ_W(SZ_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .base(w_base), .target(w_target), .size(w_size), .en(w_en),
        .misalign(misalign_flags)
    );

    iwx_matcher #(
        .NUM_WIN(NUM_WIN), .RC_WINS(RC_WINS), .ADDR_W(ADDR_W),
        .WIN_IDX_W(WIN_IDX_W), .SZ_W(SZ_W)
    ) u_match (
        .rc_mode(rc_mode), .in_addr(in_addr),
        .base(w_base), .target(w_target), .size(w_size), .en(w_en),
        .hit(m_hit), .miss(m_miss), .win(m_win), .xaddr(m_addr)
    );

    iwx_out_stage #(
        .ADDR_W(ADDR_W), .WIN_IDX_W(WIN_IDX_W)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .nx_hit(m_hit), .nx_miss(m_miss), .nx_win(m_win), .nx_addr(m_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
        .out_miss(out_miss), .out_win(out_win), .out_addr(out_addr)
    );

endmodule

// File: rtl/iwx_checker.sv
module iwx_checker #(
    parameter int NUM_WIN   = 6,
    parameter int RC_WINS   = 2,
    parameter int ADDR_W    = 32,
    parameter int WIN_IDX_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rc_mode,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [ADDR_W-1:0]    out_addr,
    input logic                 out_hit,
    input logic                 out_miss,
    input logic [WIN_IDX_W-1:0] out_win,
    input logic [NUM_WIN-1:0]   misalign_flags
);
    a_r4_miss_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_miss) |-> (out_addr == '0 && !out_hit));

    a_r1_win_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_hit) |-> (int'(out_win) < NUM_WIN));

    a_r5_rc_no_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && rc_mode) |=> (out_valid && !out_miss));

    a_r5_rc_win_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && rc_mode) |=> (!out_hit || int'(out_win) < RC_WINS));

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_win)
                                       && $stable(out_hit) && $stable(out_miss)));

    a_r9_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r8_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((misalign_flags & $past(misalign_flags)) == $past(misalign_flags)));

endmodule

bind inbound_win_xlate iwx_checker #(
    .NUM_WIN(NUM_WIN), .RC_WINS(RC_WINS), .ADDR_W(ADDR_W), .WIN_IDX_W(WIN_IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rc_mode(rc_mode), .in_valid(in_valid),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_hit(out_hit), .out_miss(out_miss),
    .out_win(out_win), .misalign_flags(misalign_flags)
);

// File: tb/inbound_win_xlate_bench.sv
module inbound_win_xlate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_WIN    = 6;
    localparam int ADDR_W     = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rc_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_win = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [5:0]  misalign_flags;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic        out_hit, out_miss;
    logic [2:0]  out_win;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0] m_base [NUM_WIN];
    logic [31:0] m_tgt  [NUM_WIN];
    int          m_sz   [NUM_WIN];
    bit          m_en   [NUM_WIN];

    always #(CLK_PERIOD/2) clk = ~clk;

    inbound_win_xlate u_inbound_win_xlate (
        .clk(clk), .rst_n(rst_n), .rc_mode(rc_mode), .cfg_we(cfg_we),
        .cfg_win(cfg_win), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .misalign_flags(misalign_flags), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_hit(out_hit), .out_miss(out_miss), .out_win(out_win)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lmask(input int s);
        return (32'd1 << s) - 32'd1;
    endfunction

    task automatic cfg_write(input int w, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_win = 3'(w); cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel == 0) m_base[w] = d;
        else if (sel == 1) m_tgt[w] = d;
        else if (sel == 2) begin
            m_en[w] = d[8];
            m_sz[w] = (int'(d[5:0]) < 12) ? 12 : ((int'(d[5:0]) > 31) ? 31 : int'(d[5:0]));
        end
    endtask

    task automatic prog_win(input int w, input logic [31:0] b, input logic [31:0] t, input int sz);
        cfg_write(w, 0, b);
        cfg_write(w, 1, t);
        cfg_write(w, 2, 32'h100 | 32'(sz));
    endtask

    task automatic model(input logic [31:0] a, output logic h, output logic ms,
                         output logic [2:0] wi, output logic [31:0] xa);
        h = 0; wi = 0; xa = rc_mode ? a : 32'd0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (m_en[i] && (!rc_mode || i < 2) && (((a ^ m_base[i]) & ~lmask(m_sz[i])) == 0)) begin
                h = 1; wi = 3'(i);
                xa = (m_tgt[i] & ~lmask(m_sz[i])) | (a & lmask(m_sz[i]));
            end
        end
        ms = !h && !rc_mode;
    endtask

    task automatic send_check(input string req, input logic [31:0] a);
        logic eh, em; logic [2:0] ew; logic [31:0] ea;
        model(a, eh, em, ew, ea);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "out_valid", 32'(out_valid), 32'd1);
        chk(req, "out_addr", out_addr, ea);
        chk(req, "out_hit", 32'(out_hit), 32'(eh));
        chk(req, "out_miss", 32'(out_miss), 32'(em));
        if (eh) chk(req, "out_win", 32'(out_win), 32'(ew));
    endtask

    task automatic expect_fixed(input string req, input logic [31:0] a, input logic [31:0] ea,
                                input logic eh, input logic [2:0] ew);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, "fixed out_addr", out_addr, ea);
        chk(req, "fixed out_hit", 32'(out_hit), 32'(eh));
        if (eh) chk(req, "fixed out_win", 32'(out_win), 32'(ew));
    endtask

    task automatic t_reset();
        chk("R10", "out_valid", 32'(out_valid), 32'd0);
        chk("R10", "in_ready", 32'(in_ready), 32'd1);
        chk("R10", "flags", 32'(misalign_flags), 32'd0);
        send_check("R10", 32'h1000_0000);
        chk("R10", "miss when all disabled", 32'(out_miss), 32'd1);
    endtask

    task automatic t_program();
        prog_win(0, 32'h1000_0000, 32'h8000_0000, 14);
        prog_win(1, 32'h2001_0000, 32'h8100_0000, 12);
        prog_win(2, 32'h2000_0000, 32'h8200_0000, 20);
        prog_win(3, 32'h3000_0000, 32'h8300_0000, 16);
        prog_win(4, 32'h4000_0000, 32'h8400_0000, 4);
        prog_win(5, 32'h5000_0000, 32'h9000_0000, 24);
        chk("R8", "aligned setup flags", 32'(misalign_flags), 32'd0);
    endtask

    task automatic t_edges();
        for (int w = 0; w < NUM_WIN; w++) begin
            send_check("R1", m_base[w]);
            send_check("R1", m_base[w] | lmask(m_sz[w]));
        end
        expect_fixed("R1", 32'h1000_3FFF, 32'h8000_3FFF, 1, 3'd0);
        expect_fixed("R2", 32'h4000_0FFF, 32'h8400_0FFF, 1, 3'd4);
        send_check("R2", 32'h4000_1000);
        chk("R2", "4KB clamp upper miss", 32'(out_miss), 32'd1);
        send_check("R4", 32'hF000_0000);
        chk("R4", "miss zero addr", out_addr, 32'd0);
        send_check("R4", 32'h1000_4000);
    endtask

    task automatic t_random();
        for (int n = 0; n < 60; n++) begin
            int w;
            logic [31:0] a;
            w = int'($urandom % NUM_WIN);
            a = m_base[w] | ($urandom & lmask(m_sz[w]));
            send_check("R1", a);
            send_check("R4", $urandom);
        end
    endtask

    task automatic t_priority();
        expect_fixed("R3", 32'h2001_0010, 32'h8100_0010, 1, 3'd1);
        expect_fixed("R3", 32'h2002_0000, 32'h8202_0000, 1, 3'd2);
    endtask

    task automatic t_disable();
        cfg_write(3, 2, 32'h0000_0010);
        send_check("R2", 32'h3000_0040);
        chk("R2", "disabled window misses", 32'(out_miss), 32'd1);
        cfg_write(3, 2, 32'h0000_0110);
        expect_fixed("R2", 32'h3000_0040, 32'h8300_0040, 1, 3'd3);
    endtask

    task automatic t_rc();
        rc_mode = 1'b1;
        expect_fixed("R5", 32'h3000_0020, 32'h3000_0020, 0, 3'd0);
        chk("R5", "no miss", 32'(out_miss), 32'd0);
        expect_fixed("R5", 32'hF000_0000, 32'hF000_0000, 0, 3'd0);
        expect_fixed("R5", 32'h1000_0004, 32'h8000_0004, 1, 3'd0);
        expect_fixed("R5", 32'h2001_0FFF, 32'h8100_0FFF, 1, 3'd1);
        for (int n = 0; n < 20; n++) send_check("R5", $urandom);
        rc_mode = 1'b0;
    endtask

    task automatic t_misalign();
        cfg_write(0, 1, 32'h7000_5000);
        chk("R8", "target misalign flag", 32'(misalign_flags), 32'h01);
        expect_fixed("R6", 32'h1000_0000, 32'h7000_4000, 1, 3'd0);
        expect_fixed("R6", 32'h1000_3FFC, 32'h7000_7FFC, 1, 3'd0);
        expect_fixed("R6", 32'h1000_1000, 32'h7000_5000, 1, 3'd0);
        cfg_write(3, 0, 32'h3000_1000);
        chk("R8", "base misalign flag", 32'(misalign_flags), 32'h09);
        expect_fixed("R7", 32'h3000_0010, 32'h8300_0010, 1, 3'd3);
        expect_fixed("R7", 32'h3000_FFFF, 32'h8300_FFFF, 1, 3'd3);
        cfg_write(0, 1, 32'h7000_4000);
        chk("R8", "sticky after aligned rewrite", 32'(misalign_flags), 32'h09);
        cfg_write(1, 2, 32'h0000_0111);
        chk("R8", "ctrl write new size", 32'(misalign_flags), 32'h0B);
    endtask

    task automatic t_stall();
        @(negedge clk);
        out_ready = 1'b0; in_valid = 1'b1; in_addr = 32'h1000_0010;
        @(negedge clk);
        chk("R9", "valid after one clock", 32'(out_valid), 32'd1);
        chk("R9", "first result", out_addr, 32'h7000_4010);
        chk("R9", "ready low on stall", 32'(in_ready), 32'd0);
        in_addr = 32'h5000_0020;
        @(negedge clk);
        chk("R9", "held result", out_addr, 32'h7000_4010);
        chk("R9", "held valid", 32'(out_valid), 32'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9", "second result", out_addr, 32'h9000_0020);
        chk("R9", "second win", 32'(out_win), 32'd5);
        @(negedge clk);
        chk("R9", "drains", 32'(out_valid), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < NUM_WIN; i++) begin
            m_base[i] = '0; m_tgt[i] = '0; m_sz[i] = 12; m_en[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_edges();
        t_random();
        t_priority();
        t_disable();
        t_rc();
        t_misalign();
        t_stall();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule